// File: doc/BRIEF.md
# Processor halt mode controller

This block executes the halt instruction of a small processor core. The decoder hands it a halt request together with a 3-bit operand, the address and length of the halt instruction, and whether the core is running in supervisor mode. The controller first waits until no earlier fault is still being resolved. It then refuses the halt with a privilege fault if the core is not in supervisor mode, or with an operand fault if the operand is out of range. Otherwise it writes the new global interrupt enable value if the operand asks for one and waits for the external bus to go idle. Only then does it enter the halted state.

While halted, the controller samples the pending interrupt every cycle. It leaves the halted state when an interrupt qualifies for delivery over the current process priority. It then emits a one-cycle resume strobe carrying the address of the instruction that follows the halt, which is where execution continues once the interrupt has been serviced. A hardware reset also ends the halted state, and in that case no resume strobe is emitted.

Top module: `halt_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `halted`, `fault_vld`, `ien_wr` and `resume_vld` are all 0.
- R2: After a request is taken, and for as long as `flt_busy` is 1, the controller stays busy and produces no fault, no enable write and no halt. The privilege and operand checks take effect two cycles after `flt_busy` falls.
- R3: When `is_super` is 0 at request time, `fault_vld` pulses for one cycle with `fault_code` = 1, whatever the operand. There is no enable write, the core does not halt, and the controller returns to idle.
- R4: In supervisor mode with operand 0, `ien_wr` pulses for one cycle with `ien_wdata` = 0 (interrupts disabled), and the halt proceeds.
- R5: In supervisor mode with operand 1, `ien_wr` pulses for one cycle with `ien_wdata` = 1 (interrupts enabled), and the halt proceeds.
- R6: In supervisor mode with operand 2, no enable write occurs, and the halt proceeds.
- R7: In supervisor mode with operand 3 to 7, `fault_vld` pulses for one cycle with `fault_code` = 2. There is no enable write and no halt.
- R8: `halted` rises only in the cycle after one in which `bus_idle` was 1. While the bus stays busy, the controller waits with `busy` = 1 and `halted` = 0.
- R9: While halted, a cycle with `irq_pend` = 1 and either `irq_prio` > `proc_prio` or `irq_prio` = 31 ends the halt on the next edge. Any other cycle leaves the controller halted.
- R10: On wake, `resume_vld` is 1 for exactly one cycle, `halted` is 0 in that cycle, and `resume_pc` equals the halt address plus the instruction length, modulo 2^ADDR_W.
- R11: Asserting reset while halted clears `halted` without any `resume_vld` pulse.
- R12: A request that arrives while the controller is busy or halted is ignored. It raises no fault, does not change the halted state, and does not change the resume address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| req | input | 1 | Decoded halt request, one cycle |
| req_op | input | OP_W (3) | Halt operand |
| req_pc | input | ADDR_W (32) | Address of the halt instruction |
| req_len | input | LEN_W (3) | Length of the halt instruction in bytes |
| is_super | input | 1 | Core is in supervisor mode |
| flt_busy | input | 1 | Earlier faults still outstanding |
| bus_idle | input | 1 | External bus has no transaction in flight |
| irq_pend | input | 1 | An interrupt is pending |
| irq_prio | input | PRIO_W (5) | Priority of the pending interrupt |
| proc_prio | input | PRIO_W (5) | Current process priority |
| busy | output | 1 | Halt sequence in progress or halted |
| halted | output | 1 | Core is in the halted state |
| fault_vld | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 1 = privilege fault, 2 = operand fault |
| ien_wr | output | 1 | One-cycle write strobe for the global interrupt enable |
| ien_wdata | output | 1 | New interrupt enable value (1 = enabled) |
| resume_vld | output | 1 | One-cycle resume strobe on wake |
| resume_pc | output | ADDR_W (32) | Address to continue at after the waking interrupt |

## Verification
The hardest case to reach is the wake decision at every boundary between interrupt and process priority. Each such case needs the core already parked in the halted state. The bench therefore re-enters the halt after every wake and walks all 32 × 32 priority pairs, presenting one pending interrupt per cycle. The non-waking pairs are checked in the same halted episode. The sync and bus waits are reached by holding `flt_busy` or dropping `bus_idle` before a request is issued. The bench then confirms that nothing moves until the input is released.

// File: rtl/halt_ctrl.sv
module halt_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OP_W   = 3,
  parameter int LEN_W  = 3,
  parameter int PRIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              is_super,
  input  logic              flt_busy,
  input  logic              bus_idle,
  input  logic              irq_pend,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] proc_prio,
  output logic              busy,
  output logic              halted,
  output logic              fault_vld,
  output logic [1:0]        fault_code,
  output logic              ien_wr,
  output logic              ien_wdata,
  output logic              resume_vld,
  output logic [ADDR_W-1:0] resume_pc
);
  localparam logic [PRIO_W-1:0] PRIO_TOP = {PRIO_W{1'b1}};
  localparam logic [OP_W-1:0]   OP_LAST  = OP_W'(2);
  localparam logic [1:0] FC_PRIV = 2'd1;
  localparam logic [1:0] FC_OPND = 2'd2;

  typedef enum logic [2:0] {IDLE, SYNC, CHECK, WAIT_BUS, HALTED, WAKE} st_t;
  st_t st;

  logic [OP_W-1:0] op_q;
  logic            sup_q;
  logic            wake;

  assign wake       = irq_pend && (irq_prio > proc_prio || irq_prio == PRIO_TOP);
  assign busy       = (st != IDLE);
  assign halted     = (st == HALTED);
  assign resume_vld = (st == WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      op_q       <= '0;
      sup_q      <= 1'b0;
      resume_pc  <= '0;
      fault_vld  <= 1'b0;
      fault_code <= 2'd0;
      ien_wr     <= 1'b0;
      ien_wdata  <= 1'b0;
    end else begin
      fault_vld <= 1'b0;
      ien_wr    <= 1'b0;
      unique case (st)
        IDLE: if (req) begin
          op_q      <= req_op;
          sup_q     <= is_super;
          resume_pc <= req_pc + ADDR_W'(req_len);
          st        <= SYNC;
        end
        SYNC: if (!flt_busy) st <= CHECK;
        CHECK: begin
          if (!sup_q) begin
            fault_vld  <= 1'b1;
            fault_code <= FC_PRIV;
            st         <= IDLE;
          end else if (op_q > OP_LAST) begin
            fault_vld  <= 1'b1;
            fault_code <= FC_OPND;
            st         <= IDLE;
          end else begin
            if (op_q != OP_LAST) begin
              ien_wr    <= 1'b1;
              ien_wdata <= op_q[0];
            end
            st <= WAIT_BUS;
          end
        end
        WAIT_BUS: if (bus_idle) st <= HALTED;
        HALTED:   if (wake) st <= WAKE;
        WAKE:     st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  a_r10_resume_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld |=> !resume_vld);

  a_r9_wake_on_qualified_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake) |=> (resume_vld && !halted));

  a_r9_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake) |=> halted);

  a_r8_bus_quiet_before_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(bus_idle));

  a_r3_r7_fault_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |-> (!busy && !ien_wr));

  a_r3_r7_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |=> !fault_vld);

  a_r2_hold_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SYNC && flt_busy) |=> (st == SYNC && !fault_vld && !ien_wr));

  a_r4_r5_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr |=> !ien_wr);
endmodule

// File: tb/sim_halt_ctrl.sv
`timescale 1ns/1ps
module sim_halt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_pc = '0;
  logic [2:0]  req_len = '0;
  logic        is_super = 1'b0;
  logic        flt_busy = 1'b0;
  logic        bus_idle = 1'b1;
  logic        irq_pend = 1'b0;
  logic [4:0]  irq_prio = '0;
  logic [4:0]  proc_prio = '0;
  logic        busy, halted, fault_vld, ien_wr, ien_wdata, resume_vld;
  logic [1:0]  fault_code;
  logic [31:0] resume_pc;

  int ncheck = 0;
  int nfail  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  halt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_pc(req_pc),
    .req_len(req_len), .is_super(is_super), .flt_busy(flt_busy),
    .bus_idle(bus_idle), .irq_pend(irq_pend), .irq_prio(irq_prio),
    .proc_prio(proc_prio), .busy(busy), .halted(halted), .fault_vld(fault_vld),
    .fault_code(fault_code), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .resume_vld(resume_vld), .resume_pc(resume_pc)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Issues a request; returns at the negedge just after the CHECK-state edge.
  task automatic issue(input bit s, input logic [2:0] op, input logic [31:0] pc, input logic [2:0] len);
    req = 1'b1; req_op = op; is_super = s; req_pc = pc; req_len = len;
    tick();
    req = 1'b0;
    tick();
    tick();
  endtask

  task automatic wake_now(input logic [31:0] exp_pc, input string rq);
    irq_pend = 1'b1; irq_prio = 5'd31;
    tick();
    irq_pend = 1'b0;
    chk(resume_vld === 1'b1, {rq, " resume strobe"}, resume_vld, 1);
    chk(halted === 1'b0, {rq, " halted low on wake"}, halted, 0);
    chk(resume_pc === exp_pc, {rq, " resume address"}, resume_pc, exp_pc);
    tick();
    chk(resume_vld === 1'b0, "R10 resume one cycle", resume_vld, 0);
    chk(busy === 1'b0, "R10 idle after wake", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        ncheck++; nfail++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    chk({busy, halted, fault_vld, ien_wr, resume_vld} === 5'b0, "R1 in reset",
        {busy, halted, fault_vld, ien_wr, resume_vld}, 0);
    rst_n = 1'b1;
    tick();
    chk({busy, halted, fault_vld, ien_wr, resume_vld} === 5'b0, "R1 after reset",
        {busy, halted, fault_vld, ien_wr, resume_vld}, 0);

    // R3 R4 R5 R6 R7 sweep over privilege and operand
    for (int s = 0; s < 2; s++) begin
      for (int op = 0; op < 8; op++) begin
        logic [31:0] pc;
        logic [2:0]  ln;
        logic [1:0]  efc;
        bit          ewr;
        pc  = 32'hFFFF_FFF0 + 32'(op * 3 + s * 40);
        ln  = 3'(op + 1);
        efc = (s == 0) ? 2'd1 : (op > 2 ? 2'd2 : 2'd0);
        ewr = (s == 1) && (op < 2);
        issue(s[0], 3'(op), pc, ln);
        chk(fault_vld === (efc != 0), "R3/R7 fault pulse", fault_vld, efc != 0);
        if (efc != 0) chk(fault_code === efc, (s == 0) ? "R3 code" : "R7 code", fault_code, efc);
        chk(ien_wr === ewr, (op == 2) ? "R6 no write" : "R4/R5 write strobe", ien_wr, ewr);
        if (ewr) chk(ien_wdata === op[0], op == 0 ? "R4 disable value" : "R5 enable value", ien_wdata, op[0]);
        tick();
        chk(fault_vld === 1'b0, "R3/R7 single fault pulse", fault_vld, 0);
        chk(ien_wr === 1'b0, "R4/R5 single write pulse", ien_wr, 0);
        chk(halted === (efc == 0), "R6 halt taken", halted, efc == 0);
        if (efc == 0) wake_now(pc + 32'(ln), "R10");
        else chk(busy === 1'b0, "R3/R7 back to idle", busy, 0);
      end
    end

    // R2 hold in sync while faults outstanding
    flt_busy = 1'b1;
    issue(1'b0, 3'd0, 32'h100, 3'd4);
    for (int k = 0; k < 5; k++) begin
      chk(busy === 1'b1 && fault_vld === 1'b0 && ien_wr === 1'b0 && halted === 1'b0,
          "R2 waits in sync", {busy, fault_vld, ien_wr, halted}, 4'b1000);
      tick();
    end
    flt_busy = 1'b0;
    tick();
    chk(fault_vld === 1'b0, "R2 no fault before check", fault_vld, 0);
    tick();
    chk(fault_vld === 1'b1 && fault_code === 2'd1, "R2 fault after release", fault_code, 1);
    tick();

    // R8 wait for bus quiescence
    bus_idle = 1'b0;
    issue(1'b1, 3'd1, 32'h2000, 3'd4);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(halted === 1'b0 && busy === 1'b1, "R8 waits for bus", {halted, busy}, 2'b01);
    end
    bus_idle = 1'b1;
    tick();
    chk(halted === 1'b1, "R8 halts once bus idle", halted, 1);

    // R12 request while halted is ignored
    req = 1'b1; req_op = 3'd7; is_super = 1'b0; req_pc = 32'h5555; req_len = 3'd2;
    tick();
    req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(fault_vld === 1'b0 && halted === 1'b1, "R12 request ignored", {fault_vld, halted}, 2'b01);
      tick();
    end
    wake_now(32'h2004, "R12");

    // R9 every priority pair
    for (int pp = 0; pp < 32; pp++) begin
      proc_prio = 5'(pp);
      issue(1'b1, 3'd2, 32'(pp * 16), 3'd2);
      tick();
      irq_pend = 1'b0; irq_prio = 5'd31;
      tick();
      chk(halted === 1'b1, "R9 no wake without pending", halted, 1);
      for (int ip = 0; ip < 32; ip++) begin
        bit ew;
        ew = (ip > pp) || (ip == 31);
        irq_pend = 1'b1; irq_prio = 5'(ip);
        tick();
        irq_pend = 1'b0;
        chk(resume_vld === ew, "R9 wake decision", resume_vld, ew);
        chk(halted === !ew, "R9 halted state", halted, !ew);
        if (ew) begin
          chk(resume_pc === 32'(pp * 16 + 2), "R10 resume address", resume_pc, pp * 16 + 2);
          tick();
          if (ip != 31) begin
            issue(1'b1, 3'd2, 32'(pp * 16), 3'd2);
            tick();
          end
        end
      end
    end
    proc_prio = '0;
    tick();

    // R11 reset exits halt without resume
    issue(1'b1, 3'd0, 32'h40, 3'd4);
    tick();
    chk(halted === 1'b1, "R11 halted before reset", halted, 1);
    rst_n = 1'b0;
    tick();
    chk(halted === 1'b0 && resume_vld === 1'b0, "R11 reset clears halt", {halted, resume_vld}, 0);
    rst_n = 1'b1;
    tick();
    chk(busy === 1'b0 && resume_vld === 1'b0, "R11 idle after reset", {busy, resume_vld}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule